// File: doc/BRIEF.md
# Accelerator Interrupt and Error-Capture Unit

This unit sits beside an accelerator core. It turns completion and error pulses from the core into sticky status bits and drives a single interrupt line. Software reaches it through a simple register port that completes in one cycle. The port gives access to a raw status word and an enable-mask word. It also exposes the status word after masking, the code of the command that failed, and a bank of error-flag words. The core sets these flag words while it runs, and software reads them once the run has ended.

In normal use software masks every source except end-of-run. An execution error still appears in the raw status word, so software reads it there after the interrupt fires. Software first reads the failing command code and then writes the observed status bits back as ones, which clears them. A small capture state machine holds the failing command. It has two states. **CAP_EMPTY** means no command is held and the code reads as zero. **CAP_HELD** means a command code has been captured. The transition EMPTY→HELD happens on an error pulse. HELD→EMPTY happens on a write that clears the error bit while no new error arrives. HELD→HELD with a reload happens when that clear write and a new error pulse arrive in the same cycle.

Top module: `accel_irq_unit`

## Requirements
- R1: After reset the raw status reads 0, the mask reads 0x013F0101 (every source disabled), the failed-command register reads 0, every flag word reads 0, and the interrupt is low.
- R2: A pulse on `ev_done` sets raw bit 0, a pulse on `ev_err` sets raw bit 24, `ev_aux[0]` sets raw bit 8, and `ev_aux[k]` for k=1..6 sets raw bit 15+k. Each bit is readable in the cycle after the pulse and stays set until cleared.
- R3: The mask register at address 1 is read/write and stores only bits 0, 8, 16..21 and 24. A mask bit of 1 disables that source. Address 2 returns the raw status AND NOT mask.
- R4: The raw status at address 0 is write-1-to-clear. Writing a 0 to a bit leaves that bit unchanged.
- R5: An error is recorded in raw bit 24 even when that source is masked, and a masked error does not raise the interrupt.
- R6: Address 3 returns, zero-extended, the command code that came with the first error after the last clear. Later errors leave it unchanged.
- R7: Clearing raw bit 24 returns the failed-command register to 0.
- R8: `irq` equals the OR of all masked-status bits, one clock cycle later.
- R9: When a source pulse and a write-1-to-clear of the same bit fall in the same cycle, the bit stays set. For the error bit, the command code of the new error is captured.
- R10: Flag word i is at address 64+i. `flag_set_valid` ORs `flag_set_bits` into word `flag_set_idx`. A write to the word clears the bits written as 1. A set wins over a clear of the same bit.
- R11: Writes to addresses 2 and 3 have no effect, and reads of addresses that decode to no register return 0.
- R12: A read request returns its data with `rsp_valid` high in the following cycle only. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_done | input | 1 | End-of-run pulse from the core |
| ev_err | input | 1 | Execution-error pulse from the core |
| ev_err_cmd | input | CMD_W | Failing command code, valid with `ev_err` |
| ev_aux | input | 7 | Spare interrupt source pulses |
| flag_set_valid | input | 1 | Flag-bit set strobe |
| flag_set_idx | input | $clog2(FLAG_N) | Flag word to set bits in |
| flag_set_bits | input | 32 | Bits to OR into the flag word |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Registered interrupt line |

## Verification
The hardest case to reach is a clear write and a new source pulse landing in the same cycle. This matters most for the error bit, where the capture machine must reload rather than empty. The stimulus drives the error pulse with a fresh command code in the same low-clock window as the clear write. It then reads back both the raw word and the command code. A second case that is hard to reach is a second error arriving while a command is already held. It is produced back to back while the error source stays masked. The check then confirms that neither the interrupt nor the held code moved.

// File: rtl/accel_irq_pkg.sv
package accel_irq_pkg;

    localparam int unsigned REG_W     = 32;
    localparam int unsigned AUX_N     = 7;
    localparam int unsigned BIT_DONE  = 0;
    localparam int unsigned BIT_ERR   = 24;
    localparam int unsigned BIT_AUX0  = 8;
    localparam int unsigned BIT_AUXHI = 15;  // aux[k], k>=1, lands on bit 15+k

    localparam logic [REG_W-1:0] SRC_BITS = 32'h013F_0101;

    localparam int unsigned ADDR_RAW   = 0;
    localparam int unsigned ADDR_MASK  = 1;
    localparam int unsigned ADDR_MSTAT = 2;
    localparam int unsigned ADDR_ECMD  = 3;
    localparam int unsigned FLAG_BASE  = 64;

    typedef enum logic {
        CAP_EMPTY = 1'b0,
        CAP_HELD  = 1'b1
    } cap_state_e;

    function automatic logic [REG_W-1:0] aux_to_raw(input logic [AUX_N-1:0] aux);
        logic [REG_W-1:0] v;
        v = '0;
        v[BIT_AUX0] = aux[0];
        for (int k = 1; k < AUX_N; k++) begin
            v[BIT_AUXHI + k] = aux[k];
        end
        return v;
    endfunction

endpackage

// File: rtl/accel_irq_status.sv
module accel_irq_status
    import accel_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_done,
    input  logic             ev_err,
    input  logic [AUX_N-1:0] ev_aux,
    input  logic             raw_clr_en,
    input  logic             mask_wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] raw_q,
    output logic [REG_W-1:0] mask_q,
    output logic [REG_W-1:0] masked
);

    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] raw_d;

    always_comb begin
        set_vec           = aux_to_raw(ev_aux);
        set_vec[BIT_DONE] = ev_done;
        set_vec[BIT_ERR]  = ev_err;
        clr_vec           = raw_clr_en ? wdata : '0;
        // a new event outranks a clear of the same bit
        raw_d             = ((raw_q & ~clr_vec) | set_vec) & SRC_BITS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q  <= '0;
            mask_q <= SRC_BITS;
        end else begin
            raw_q <= raw_d;
            if (mask_wr_en) begin
                mask_q <= wdata & SRC_BITS;
            end
        end
    end

    assign masked = raw_q & ~mask_q;

endmodule

// File: rtl/accel_irq_cap.sv
module accel_irq_cap
    import accel_irq_pkg::*;
#(
    parameter int unsigned CMD_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_evt,
    input  logic [CMD_W-1:0] err_cmd_in,
    input  logic             err_clr,
    output logic             held,
    output logic [CMD_W-1:0] cmd_q
);

    cap_state_e state_q;
    cap_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_EMPTY: if (err_evt) state_d = CAP_HELD;
            CAP_HELD:  if (err_clr && !err_evt) state_d = CAP_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CAP_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else begin
            unique case (state_q)
                CAP_EMPTY: if (err_evt) cmd_q <= err_cmd_in;
                CAP_HELD:  if (err_clr) cmd_q <= err_evt ? err_cmd_in : '0;
            endcase
        end
    end

    assign held = (state_q == CAP_HELD);

endmodule

// File: rtl/accel_irq_flags.sv
module accel_irq_flags
    import accel_irq_pkg::*;
#(
    parameter int unsigned FLAG_N = 32,
    localparam int unsigned IDX_W = $clog2(FLAG_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_valid,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [REG_W-1:0] set_bits,
    input  logic             clr_valid,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic [REG_W-1:0] clr_bits,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [REG_W-1:0] rd_word
);

    logic [REG_W-1:0] word_q [FLAG_N];

    for (genvar i = 0; i < FLAG_N; i++) begin : g_word
        logic [REG_W-1:0] s;
        logic [REG_W-1:0] c;
        assign s = (set_valid && set_idx == IDX_W'(i)) ? set_bits : '0;
        assign c = (clr_valid && clr_idx == IDX_W'(i)) ? clr_bits : '0;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q[i] <= '0;
            end else begin
                word_q[i] <= (word_q[i] & ~c) | s;
            end
        end
    end

    assign rd_word = word_q[rd_idx];

endmodule

// File: rtl/accel_irq_unit.sv
module accel_irq_unit
    import accel_irq_pkg::*;
#(
    parameter int unsigned CMD_W  = 16,
    parameter int unsigned FLAG_N = 32,
    parameter int unsigned ADDR_W = 7,
    localparam int unsigned IDX_W = $clog2(FLAG_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_done,
    input  logic              ev_err,
    input  logic [CMD_W-1:0]  ev_err_cmd,
    input  logic [AUX_N-1:0]  ev_aux,
    input  logic              flag_set_valid,
    input  logic [IDX_W-1:0]  flag_set_idx,
    input  logic [REG_W-1:0]  flag_set_bits,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [REG_W-1:0]  req_wdata,
    output logic              rsp_valid,
    output logic [REG_W-1:0]  rsp_rdata,
    output logic              irq
);

    logic [REG_W-1:0] raw_q;
    logic [REG_W-1:0] mask_q;
    logic [REG_W-1:0] masked;
    logic             cap_held;
    logic [CMD_W-1:0] err_cmd;
    logic [REG_W-1:0] flag_word;

    logic             wr_en;
    logic             rd_en;
    logic             hit_flag;
    logic [IDX_W-1:0] flag_idx;
    logic [ADDR_W:0]  flag_off;

    assign wr_en    = req_valid && req_write;
    assign rd_en    = req_valid && !req_write;
    assign flag_off = {1'b0, req_addr} - (ADDR_W+1)'(FLAG_BASE);
    assign hit_flag = ({1'b0, req_addr} >= (ADDR_W+1)'(FLAG_BASE)) &&
                      (flag_off < (ADDR_W+1)'(FLAG_N));
    assign flag_idx = flag_off[IDX_W-1:0];

    accel_irq_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_done    (ev_done),
        .ev_err     (ev_err),
        .ev_aux     (ev_aux),
        .raw_clr_en (wr_en && req_addr == ADDR_W'(ADDR_RAW)),
        .mask_wr_en (wr_en && req_addr == ADDR_W'(ADDR_MASK)),
        .wdata      (req_wdata),
        .raw_q      (raw_q),
        .mask_q     (mask_q),
        .masked     (masked)
    );

    accel_irq_cap #(.CMD_W(CMD_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_evt    (ev_err),
        .err_cmd_in (ev_err_cmd),
        .err_clr    (wr_en && req_addr == ADDR_W'(ADDR_RAW) && req_wdata[BIT_ERR]),
        .held       (cap_held),
        .cmd_q      (err_cmd)
    );

    accel_irq_flags #(.FLAG_N(FLAG_N)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_valid (flag_set_valid),
        .set_idx   (flag_set_idx),
        .set_bits  (flag_set_bits),
        .clr_valid (wr_en && hit_flag),
        .clr_idx   (flag_idx),
        .clr_bits  (req_wdata),
        .rd_idx    (flag_idx),
        .rd_word   (flag_word)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            irq       <= 1'b0;
        end else begin
            irq       <= |masked;
            rsp_valid <= rd_en;
            if (rd_en) begin
                if (hit_flag) begin
                    rsp_rdata <= flag_word;
                end else begin
                    unique case (int'(req_addr))
                        ADDR_RAW:   rsp_rdata <= raw_q;
                        ADDR_MASK:  rsp_rdata <= mask_q;
                        ADDR_MSTAT: rsp_rdata <= masked;
                        ADDR_ECMD:  rsp_rdata <= {{(REG_W-CMD_W){1'b0}}, err_cmd};
                        default:    rsp_rdata <= '0;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/accel_irq_unit_chk.sv
module accel_irq_unit_chk
    import accel_irq_pkg::*;
#(
    parameter int unsigned CMD_W  = 16,
    parameter int unsigned ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_done,
    input logic              ev_err,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [REG_W-1:0]  req_wdata,
    input logic [REG_W-1:0]  raw,
    input logic [REG_W-1:0]  mask,
    input logic              cap_held,
    input logic [CMD_W-1:0]  err_cmd,
    input logic              rsp_valid,
    input logic              irq
);

    logic clr_err;
    assign clr_err = req_valid && req_write && req_addr == ADDR_W'(ADDR_RAW) && req_wdata[BIT_ERR];

    a_r2_done_latched: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done |=> raw[BIT_DONE]);

    a_r5_err_latched: assert property (@(posedge clk) disable iff (!rst_n)
        ev_err |=> raw[BIT_ERR]);

    a_r6_cmd_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (raw[BIT_ERR] && !clr_err) |=> $stable(err_cmd));

    a_r6_state_matches: assert property (@(posedge clk) disable iff (!rst_n)
        cap_held == raw[BIT_ERR]);

    a_r7_cmd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !raw[BIT_ERR] |-> err_cmd == '0);

    a_r8_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq == $past(|(raw & ~mask)));

    a_r12_rsp_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    a_r12_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);

endmodule

bind accel_irq_unit accel_irq_unit_chk #(.CMD_W(CMD_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_done   (ev_done),
    .ev_err    (ev_err),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .raw       (raw_q),
    .mask      (mask_q),
    .cap_held  (cap_held),
    .err_cmd   (err_cmd),
    .rsp_valid (rsp_valid),
    .irq       (irq)
);

// File: tb/test_accel_irq_unit.sv
module test_accel_irq_unit;

    localparam int CMD_W  = 16;
    localparam int FLAG_N = 32;
    localparam int ADDR_W = 7;
    localparam int IDX_W  = $clog2(FLAG_N);
    localparam logic [31:0] M_NORMAL = 32'h013F_0100;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ev_done = 1'b0;
    logic              ev_err = 1'b0;
    logic [CMD_W-1:0]  ev_err_cmd = '0;
    logic [6:0]        ev_aux = '0;
    logic              flag_set_valid = 1'b0;
    logic [IDX_W-1:0]  flag_set_idx = '0;
    logic [31:0]       flag_set_bits = '0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid;
    logic [31:0]       rsp_rdata;
    logic              irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    accel_irq_unit #(.CMD_W(CMD_W), .FLAG_N(FLAG_N), .ADDR_W(ADDR_W)) i_accel_irq_unit (
        .clk(clk), .rst_n(rst_n), .ev_done(ev_done), .ev_err(ev_err),
        .ev_err_cmd(ev_err_cmd), .ev_aux(ev_aux), .flag_set_valid(flag_set_valid),
        .flag_set_idx(flag_set_idx), .flag_set_bits(flag_set_bits),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // monitor: pops scoreboard entries as read data arrives
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R12 unexpected response", rsp_rdata, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rsp_rdata === e, t, rsp_rdata, e);
            end
        end
    end

    task automatic rd(input int addr, input logic [31:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = ADDR_W'(addr);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid === 1'b1, "R12 response one cycle after read", {31'b0, rsp_valid}, 32'h1);
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = ADDR_W'(addr); req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_err(input logic [CMD_W-1:0] cmd);
        @(negedge clk);
        ev_err = 1'b1; ev_err_cmd = cmd;
        @(negedge clk);
        ev_err = 1'b0;
    endtask

    task automatic set_flag(input int idx, input logic [31:0] bits);
        @(negedge clk);
        flag_set_valid = 1'b1; flag_set_idx = IDX_W'(idx); flag_set_bits = bits;
        @(negedge clk);
        flag_set_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R12 watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        chk(irq === 1'b0, "R1 irq after reset", {31'b0, irq}, 32'h0);
        rd(0, 32'h0, "R1 raw after reset");
        rd(1, 32'h013F_0101, "R1 mask after reset");
        rd(3, 32'h0, "R1 cmd after reset");
        rd(64, 32'h0, "R1 flag after reset");
        // R3 mask keeps only implemented bits
        wr(1, 32'hFFFF_FFFF);
        rd(1, 32'h013F_0101, "R3 mask implemented bits");
        wr(1, M_NORMAL);
        rd(1, M_NORMAL, "R3 mask readback");
        // R2 / R8 end-of-run
        @(negedge clk); ev_done = 1'b1; @(negedge clk); ev_done = 1'b0;
        rd(0, 32'h1, "R2 done sets bit0");
        rd(2, 32'h1, "R3 masked status");
        chk(irq === 1'b1, "R8 irq raised", {31'b0, irq}, 32'h1);
        // R4 write 0 no effect, write 1 clears
        wr(0, 32'h0);
        rd(0, 32'h1, "R4 zero write ignored");
        wr(0, 32'h1);
        idle(1);
        chk(irq === 1'b0, "R8 irq dropped", {31'b0, irq}, 32'h0);
        rd(0, 32'h0, "R4 w1c clears");
        // R5 masked error, R6 first command captured
        pulse_err(16'h005A);
        rd(0, 32'h0100_0000, "R5 masked error in raw");
        rd(2, 32'h0, "R5 masked error hidden");
        chk(irq === 1'b0, "R5 no irq for masked error", {31'b0, irq}, 32'h0);
        rd(3, 32'h5A, "R6 first command");
        pulse_err(16'h0033);
        rd(3, 32'h5A, "R6 later error ignored");
        // R11 read-only and undecoded
        wr(2, 32'hFFFF_FFFF);
        wr(3, 32'hFFFF_FFFF);
        rd(3, 32'h5A, "R11 cmd write ignored");
        rd(0, 32'h0100_0000, "R11 mstat write ignored");
        rd(5, 32'h0, "R11 undecoded reads zero");
        // R7 clear resets command
        wr(0, 32'h0100_0000);
        rd(0, 32'h0, "R7 error bit cleared");
        rd(3, 32'h0, "R7 command reset");
        // R9 error event during clear
        pulse_err(16'h0011);
        @(negedge clk);
        ev_err = 1'b1; ev_err_cmd = 16'h0077;
        req_valid = 1'b1; req_write = 1'b1; req_addr = '0; req_wdata = 32'h0100_0000;
        @(negedge clk);
        ev_err = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        rd(0, 32'h0100_0000, "R9 error survives clear");
        rd(3, 32'h77, "R9 new command captured");
        wr(0, 32'h0100_0000);
        // R9 done event during clear
        @(negedge clk);
        ev_done = 1'b1;
        req_valid = 1'b1; req_write = 1'b1; req_addr = '0; req_wdata = 32'h1;
        @(negedge clk);
        ev_done = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        rd(0, 32'h1, "R9 done survives clear");
        wr(0, 32'h1);
        // R2 aux mapping, R3 masking, R8 after unmask
        @(negedge clk); ev_aux = 7'b000_0011; @(negedge clk); ev_aux = '0;
        rd(0, 32'h0001_0100, "R2 aux bits 8 and 16");
        chk(irq === 1'b0, "R3 aux masked no irq", {31'b0, irq}, 32'h0);
        wr(1, M_NORMAL & ~32'h100);
        idle(1);
        chk(irq === 1'b1, "R8 irq after unmask", {31'b0, irq}, 32'h1);
        wr(0, 32'h0001_0100);
        wr(1, M_NORMAL);
        // R10 flag bank
        set_flag(5, 32'hA0);
        set_flag(5, 32'h03);
        set_flag(31, 32'h1);
        rd(64 + 5, 32'hA3, "R10 flag OR set");
        rd(64 + 31, 32'h1, "R10 last flag word");
        rd(64, 32'h0, "R10 other word untouched");
        wr(64 + 5, 32'h20);
        rd(64 + 5, 32'h83, "R10 flag w1c");
        idle(3);
        chk(exp_q.size() == 0, "R12 all reads answered", exp_q.size(), 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule